// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block collects 64 level-sensitive interrupt sources and turns them into two processor requests: a normal request and a fast request. Each source has an enable bit, a type bit that routes it to the fast request when set, and a 4-bit priority. A 5-bit threshold register gates the normal request by priority. Software reaches all state through a 32-bit word-addressed register interface.

Reads are strobed by `rd_i`. The data and an error flag appear one cycle later. Software can enable or disable one source by writing its number. It can read and write the 64-bit vectors as two 32-bit halves, overwrite the pending state for one cycle, and read views of the pending vector filtered by enable and type. Two status words report the winning normal source and the winning fast source. Writes to the vector-table window are ignored.

Top module: `vic_bank`

## Requirements
- R1: After reset, the following are all zero: enable, type, control, threshold and all priorities. The requests are low. Both status words read 0xFFFFFFFF.
- R2: A write of n to word 0x08 sets enable bit n, and a write of n to word 0x0C clears it. A value of 64 or more changes nothing. Both words read as zero.
- R3: Word 0x10 holds enable bits 63..32 and word 0x14 holds bits 31..0. Words 0x18 and 0x1C hold the type bits in the same split. A set type bit marks a fast source. Each of these words is read/write.
- R4: `fiq_o` is high exactly when some source is pending, enabled and of fast type.
- R5: `irq_o` is high exactly when some source that is pending, enabled and not fast has a priority strictly greater than the threshold. A threshold of 0x1F lets any such source through. A threshold of 16 to 30 blocks all of them.
- R6: Each cycle, pending bit i takes the level of `src_i[i]`. Word 0x48 reads pending bits 63..32 and word 0x4C reads bits 31..0.
- R7: A write to word 0x50 (high half) or 0x54 (low half) replaces that half of pending with the write data for one cycle, in place of the source levels. These words read zero.
- R8: Words 0x58/0x5C read pending&enable&~type (high/low). Words 0x60/0x64 read pending&enable&type.
- R9: Priority word at 0x20+4k holds sources 8*(7-k) to 8*(7-k)+7, four bits each. The lowest nibble belongs to the lowest source number.
- R10: Word 0x40 reads (n<<16)|p for the normal candidate n with the highest priority p. On a tie, the highest n wins. With no candidate, it reads 0xFFFFFFFF.
- R11: Word 0x44 reads the lowest-numbered pending, enabled fast source, or 0xFFFFFFFF if there is none.
- R12: The threshold (word 0x04) keeps only write bits 4..0. The control word (0x00) reads back the full written value.
- R13: Writes to words 0x40–0x4C, 0x58–0x64 and any offset beyond 0x64 (including the vector table at 0x100–0x2FC) change no state.
- R14: Read data is valid one cycle after `rd_i`. A read of an offset beyond 0x64 returns zero and pulses `err_o` for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source levels |
| addr_i | input | 12 | Byte address, word aligned |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, one cycle after rd_i |
| err_o | output | 1 | Unmapped read, one cycle after rd_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The forced pending state is the hardest condition to observe, because it lasts a single cycle before the source levels take over again. The stimulus writes a force half and samples both request outputs in the next cycle. It then issues a raw-source read right away, so the read captures the forced value before it is overwritten. The threshold edges (equal priority, 16 to 30, and 0x1F) and status ties are set up directly. Random mixes of enable, type, priority and source changes then cover the rest of the state space.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DATA_W = 32;
  // word indices (byte offset >> 2)
  localparam int WI_CTRL    = 0;
  localparam int WI_THR     = 1;
  localparam int WI_ENNUM   = 2;
  localparam int WI_DISNUM  = 3;
  localparam int WI_EN_HI   = 4;
  localparam int WI_EN_LO   = 5;
  localparam int WI_TYP_HI  = 6;
  localparam int WI_TYP_LO  = 7;
  localparam int WI_PRIO0   = 8;
  localparam int WI_PRIO7   = 15;
  localparam int WI_NSTAT   = 16;
  localparam int WI_FSTAT   = 17;
  localparam int WI_RAW_HI  = 18;
  localparam int WI_RAW_LO  = 19;
  localparam int WI_FRC_HI  = 20;
  localparam int WI_FRC_LO  = 21;
  localparam int WI_NPND_HI = 22;
  localparam int WI_NPND_LO = 23;
  localparam int WI_FPND_HI = 24;
  localparam int WI_FPND_LO = 25;
  localparam int WI_LAST    = 25;
endpackage

// File: rtl/vic_gate.sv
module vic_gate #(
  parameter int N    = 64,
  parameter int PW   = 4,
  parameter int MW   = 5
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [MW-1:0]   thr_i,
  output logic            req_o
);
  logic open_all;
  assign open_all = &thr_i;

  always_comb begin
    req_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (open_all || ({{(MW-PW){1'b0}}, prio_i[i*PW +: PW]} > thr_i)))
        req_o = 1'b1;
    end
  end
endmodule

// File: rtl/vic_norm_sel.sv
module vic_norm_sel #(
  parameter int N  = 64,
  parameter int PW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  // later index wins on equal priority
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i*PW +: PW] >= prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/vic_fast_sel.sv
module vic_fast_sel #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (cand_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_bank.sv
module vic_bank #(
  parameter int N      = 64,
  parameter int PW     = 4,
  parameter int MW     = 5,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              fiq_o
);
  import vic_pkg::*;

  localparam int IW      = $clog2(N);
  localparam int HALF    = N / 2;
  localparam int PWORDS  = (N * PW) / DATA_W;

  logic [31:0]     ctrl_q;
  logic [MW-1:0]   mask_q;
  logic [N-1:0]    en_q, typ_q, pend_q, pend_d;
  logic [N*PW-1:0] prio_q;

  logic [31:0] wsel;
  logic [1:0]  unused_lsb;
  assign wsel       = 32'(addr_i[ADDR_W-1:2]);
  assign unused_lsb = addr_i[1:0];

  logic num_ok;
  assign num_ok = (wdata_i < 32'(N));

  // pending mirrors source levels; force write overrides for one cycle
  always_comb begin
    pend_d = src_i;
    if (we_i && wsel == WI_FRC_HI) pend_d[N-1:HALF] = wdata_i;
    if (we_i && wsel == WI_FRC_LO) pend_d[HALF-1:0] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      prio_q <= '0;
    end else if (we_i) begin
      case (wsel)
        WI_CTRL:   ctrl_q <= wdata_i;
        WI_THR:    mask_q <= wdata_i[MW-1:0];
        WI_ENNUM:  if (num_ok) en_q[wdata_i[IW-1:0]] <= 1'b1;
        WI_DISNUM: if (num_ok) en_q[wdata_i[IW-1:0]] <= 1'b0;
        WI_EN_HI:  en_q[N-1:HALF]  <= wdata_i;
        WI_EN_LO:  en_q[HALF-1:0]  <= wdata_i;
        WI_TYP_HI: typ_q[N-1:HALF] <= wdata_i;
        WI_TYP_LO: typ_q[HALF-1:0] <= wdata_i;
        default: begin
          if (wsel >= WI_PRIO0 && wsel <= WI_PRIO7)
            prio_q[(PWORDS-1-(wsel-WI_PRIO0))*DATA_W +: DATA_W] <= wdata_i;
        end
      endcase
    end
  end

  logic [N-1:0] norm_cand, fast_cand;
  assign norm_cand = pend_q & en_q & ~typ_q;
  assign fast_cand = pend_q & en_q & typ_q;

  logic          norm_valid, fast_valid;
  logic [IW-1:0] norm_idx, fast_idx;
  logic [PW-1:0] norm_prio;

  vic_gate #(.N(N), .PW(PW), .MW(MW)) u_gate (
    .cand_i(norm_cand), .prio_i(prio_q), .thr_i(mask_q), .req_o(irq_o)
  );

  vic_norm_sel #(.N(N), .PW(PW)) u_nsel (
    .cand_i(norm_cand), .prio_i(prio_q),
    .valid_o(norm_valid), .idx_o(norm_idx), .prio_o(norm_prio)
  );

  vic_fast_sel #(.N(N)) u_fsel (
    .cand_i(fast_cand), .valid_o(fast_valid), .idx_o(fast_idx)
  );

  assign fiq_o = |fast_cand;

  logic [31:0] rd_val;
  logic        rd_hit;
  always_comb begin
    rd_val = '0;
    rd_hit = (wsel <= WI_LAST);
    case (wsel)
      WI_CTRL:    rd_val = ctrl_q;
      WI_THR:     rd_val = 32'(mask_q);
      WI_EN_HI:   rd_val = en_q[N-1:HALF];
      WI_EN_LO:   rd_val = en_q[HALF-1:0];
      WI_TYP_HI:  rd_val = typ_q[N-1:HALF];
      WI_TYP_LO:  rd_val = typ_q[HALF-1:0];
      WI_NSTAT:   rd_val = norm_valid ? ((32'(norm_idx) << 16) | 32'(norm_prio)) : '1;
      WI_FSTAT:   rd_val = fast_valid ? 32'(fast_idx) : '1;
      WI_RAW_HI:  rd_val = pend_q[N-1:HALF];
      WI_RAW_LO:  rd_val = pend_q[HALF-1:0];
      WI_NPND_HI: rd_val = norm_cand[N-1:HALF];
      WI_NPND_LO: rd_val = norm_cand[HALF-1:0];
      WI_FPND_HI: rd_val = fast_cand[N-1:HALF];
      WI_FPND_LO: rd_val = fast_cand[HALF-1:0];
      default: begin
        if (wsel >= WI_PRIO0 && wsel <= WI_PRIO7)
          rd_val = prio_q[(PWORDS-1-(wsel-WI_PRIO0))*DATA_W +: DATA_W];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= rd_i && !rd_hit;
      if (rd_i) rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/vic_bank_chk.sv
module vic_bank_chk #(
  parameter int N      = 64,
  parameter int PW     = 4,
  parameter int MW     = 5,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic              rd_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      pend_q,
  input logic [MW-1:0]     mask_q,
  input logic              norm_valid,
  input logic [PW-1:0]     norm_prio,
  input logic              fast_valid
);
  localparam int IW = $clog2(N);
  logic [ADDR_W-3:0] widx;
  assign widx = addr_i[ADDR_W-1:2];

  a_r2_enable_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == 2 && wdata_i < 32'(N)) |=> en_q[$past(wdata_i[IW-1:0])]);

  a_r2_disable_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == 3 && wdata_i < 32'(N)) |=> !en_q[$past(wdata_i[IW-1:0])]);

  a_r2_numreg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (widx == 2 || widx == 3)) |=> rdata_o == '0);

  a_r4_fiq_enc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == fast_valid);

  a_r5_irq_best: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (norm_valid && ((&mask_q) || ({1'b0, norm_prio} > mask_q))));

  a_r7_force_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == 21) |=> pend_q[N/2-1:0] == $past(wdata_i));

  a_r14_err_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(rd_i) && rdata_o == '0));
endmodule

bind vic_bank vic_bank_chk #(.N(N), .PW(PW), .MW(MW), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vic_bank_tb_top.sv
module vic_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic        err_o, irq_o, fiq_o;

  always #5 clk_i = ~clk_i;

  vic_bank dut_i (.*);

  int checks = 0, errors = 0;

  bit [63:0] pend_m, en_m, typ_m;
  bit [3:0]  prio_m [64];
  bit [4:0]  mask_m;
  bit [31:0] ctrl_m;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit exp_irq(bit [63:0] p);
    bit [63:0] c = p & en_m & ~typ_m;
    for (int i = 0; i < 64; i++)
      if (c[i] && (mask_m == 5'h1F || {1'b0, prio_m[i]} > mask_m)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_fiq(bit [63:0] p);
    return |(p & en_m & typ_m);
  endfunction

  function automatic bit [31:0] exp_read(int wi);
    bit [63:0] nc = pend_m & en_m & ~typ_m;
    bit [63:0] fc = pend_m & en_m & typ_m;
    bit [31:0] v = '0;
    case (wi)
      0: v = ctrl_m;
      1: v = 32'(mask_m);
      4: v = en_m[63:32];
      5: v = en_m[31:0];
      6: v = typ_m[63:32];
      7: v = typ_m[31:0];
      16: begin
        int best = -1;
        for (int i = 0; i < 64; i++)
          if (nc[i] && (best < 0 || prio_m[i] >= prio_m[best])) best = i;
        v = (best < 0) ? 32'hFFFF_FFFF : ((32'(best) << 16) | 32'(prio_m[best]));
      end
      17: begin
        v = 32'hFFFF_FFFF;
        for (int i = 63; i >= 0; i--) if (fc[i]) v = 32'(i);
      end
      18: v = pend_m[63:32];
      19: v = pend_m[31:0];
      22: v = nc[63:32];
      23: v = nc[31:0];
      24: v = fc[63:32];
      25: v = fc[31:0];
      default: begin
        if (wi >= 8 && wi <= 15)
          for (int j = 0; j < 8; j++) v[4*j +: 4] = prio_m[(15-wi)*8 + j];
      end
    endcase
    return v;
  endfunction

  // called at a negedge, returns at the next negedge
  task automatic bus_wr(int wi, bit [31:0] d);
    addr_i = 12'(wi * 4); wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic wr(int wi, bit [31:0] d);
    bus_wr(wi, d);
    case (wi)
      0: ctrl_m = d;
      1: mask_m = d[4:0];
      2: if (d < 64) en_m[d[5:0]] = 1'b1;
      3: if (d < 64) en_m[d[5:0]] = 1'b0;
      4: en_m[63:32] = d;
      5: en_m[31:0] = d;
      6: typ_m[63:32] = d;
      7: typ_m[31:0] = d;
      default: if (wi >= 8 && wi <= 15)
        for (int j = 0; j < 8; j++) prio_m[(15-wi)*8 + j] = d[4*j +: 4];
    endcase
  endtask

  task automatic rd(int addr, output logic [31:0] v, output logic e);
    addr_i = 12'(addr); rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    v = rdata_o; e = err_o;
  endtask

  task automatic set_src(bit [63:0] s);
    src_i = s;
    @(negedge clk_i);
    pend_m = s;
  endtask

  task automatic set_prio(int s, bit [3:0] p);
    bit [31:0] w = '0;
    int wi = 15 - s / 8;
    prio_m[s] = p;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = prio_m[(s/8)*8 + j];
    wr(wi, w);
  endtask

  task automatic chk_reqs(string tag);
    chk({tag, " irq"}, 32'(irq_o), 32'(exp_irq(pend_m)));
    chk({tag, " fiq"}, 32'(fiq_o), 32'(exp_fiq(pend_m)));
  endtask

  task automatic chk_all(string tag);
    logic [31:0] v; logic e;
    for (int wi = 0; wi <= 25; wi++) begin
      if (wi == 20 || wi == 21) continue;
      rd(wi * 4, v, e);
      chk($sformatf("%s word %0d", tag, wi), v, exp_read(wi));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v; logic e;
    void'($urandom(32'd20240611));
    pend_m = '0; en_m = '0; typ_m = '0; mask_m = '0; ctrl_m = '0;
    for (int i = 0; i < 64; i++) prio_m[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    chk_all("R1");

    // R12 threshold width and control readback
    wr(1, 32'hFFFF_FFE3);
    rd(4, v, e); chk("R12 mask", v, 32'h3);
    wr(0, 32'hDEAD_A5A5);
    rd(0, v, e); chk("R12 ctrl", v, 32'hDEAD_A5A5);

    // R2 enable/disable by number
    wr(2, 37); wr(2, 0); wr(2, 63); wr(2, 64); wr(2, 32'hFFFF_FFFF);
    rd(16, v, e); chk("R2 en hi", v, 32'h8000_0020);
    rd(20, v, e); chk("R2 en lo", v, 32'h1);
    wr(3, 63); wr(3, 100);
    rd(16, v, e); chk("R2 dis hi", v, 32'h0000_0020);
    rd(8, v, e);  chk("R2 numreg zero", v, 0);

    // R3 halves
    wr(4, 32'h1234_5678); wr(7, 32'h0F0F_0000);
    rd(16, v, e); chk("R3 en hi", v, 32'h1234_5678);
    rd(28, v, e); chk("R3 typ lo", v, 32'h0F0F_0000);
    wr(4, 0); wr(5, 0); wr(7, 0);

    // R5 threshold corners on source 3
    wr(2, 3); set_prio(3, 4'd15); set_src(64'h8);
    wr(1, 16); chk("R5 thr16 blocks", 32'(irq_o), 0);
    wr(1, 30); chk("R5 thr30 blocks", 32'(irq_o), 0);
    wr(1, 15); chk("R5 thr equal blocks", 32'(irq_o), 0);
    wr(1, 14); chk("R5 thr below passes", 32'(irq_o), 1);
    wr(1, 31); set_prio(3, 4'd0);
    chk("R5 thr 1F passes prio0", 32'(irq_o), 1);
    wr(1, 0); chk("R5 prio0 thr0 blocks", 32'(irq_o), 0);

    // R10 tie: sources 3 and 40 same priority -> 40
    wr(2, 40); set_prio(40, 4'd0); set_src(64'h0000_0100_0000_0008);
    rd(64, v, e); chk("R10 tie high number", v, (32'd40 << 16));
    set_prio(3, 4'd7);
    rd(64, v, e); chk("R10 higher prio", v, (32'd3 << 16) | 7);

    // R4/R11 fast routing, lowest number wins
    wr(6, 32'h0000_0100); wr(2, 35); wr(7, 32'h8);
    set_src(64'h0000_0108_0000_0008);
    chk("R4 fiq", 32'(fiq_o), 1);
    rd(68, v, e); chk("R11 fast lowest", v, 3);
    rd(96, v, e); chk("R8 fast pend hi", v, exp_read(24));
    rd(88, v, e); chk("R8 norm pend hi", v, exp_read(22));

    // R7 force low/high for one cycle
    set_src('0);
    bus_wr(21, 32'h0000_0008);
    chk("R7 force fiq", 32'(fiq_o), 1);
    rd(76, v, e); chk("R7 raw lo forced", v, 32'h8);
    chk("R6 reverts to src", 32'(fiq_o), 0);
    rd(76, v, e); chk("R6 raw lo src", v, 0);

    // R13 writes to read-only and vector table ignored
    set_src(64'h00FF_0000_0000_F000);
    bus_wr(18, 32'hFFFF_FFFF); bus_wr(19, 32'hFFFF_FFFF);
    bus_wr(16, 32'h0); bus_wr(17, 32'h0); bus_wr(22, 32'hFFFF_FFFF);
    bus_wr(25, 32'hFFFF_FFFF); bus_wr(64, 32'hFFFF_FFFF); bus_wr(100, 32'h1F);
    bus_wr(190, 32'hFFFF_FFFF);
    chk_all("R13");

    // R14 unmapped read
    rd(12'h100, v, e);
    chk("R14 unmapped data", v, 0); chk("R14 err", 32'(e), 1);
    rd(0, v, e); chk("R14 err clears", 32'(e), 0);
    rd(12'h068, v, e); chk("R14 just past map", 32'(e), 1);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 10;
      case (op)
        0: set_src({$urandom, $urandom} & {$urandom, $urandom});
        1: wr(2, $urandom % 80);
        2: wr(3, $urandom % 80);
        3: wr(4 + ($urandom % 2), $urandom);
        4: wr(6 + ($urandom % 2), $urandom & $urandom);
        5: wr(8 + ($urandom % 8), $urandom);
        6: wr(1, ($urandom % 4 == 0) ? 32'h1F : $urandom);
        7: begin
          int wi = $urandom % 26;
          if (wi == 20 || wi == 21) wi = 16;
          rd(wi * 4, v, e);
          chk($sformatf("R8/R9/R10/R11 rand word %0d", wi), v, exp_read(wi));
          chk("R14 rand no err", 32'(e), 0);
        end
        8: begin
          bit hi = 1'($urandom % 2);
          bit [31:0] d = $urandom;
          bit [63:0] pf = pend_m;
          if (hi) pf[63:32] = d; else pf[31:0] = d;
          bus_wr(hi ? 20 : 21, d);
          chk("R7 rand force irq", 32'(irq_o), 32'(exp_irq(pf)));
          chk("R7 rand force fiq", 32'(fiq_o), 32'(exp_fiq(pf)));
          rd(hi ? 72 : 76, v, e);
          chk("R7 rand force raw", v, d);
        end
        default: set_prio($urandom % 64, 4'($urandom));
      endcase
      chk_reqs("R4/R5 rand");
    end
    chk_all("R6 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule